// File: doc/BRIEF.md
# No-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM whose data bus never needs an idle cycle when traffic switches between reads and writes. The internal array holds 72-bit words made of eight 9-bit byte lanes. Every command input (address, chip enables, write strobe, advance, byte enables) is registered on the rising clock edge. Write data is taken late, one or two cycles after its address, so that the write data slot lines up exactly with the read data slot of the selected mode.

A static mode input picks pipelined operation (the read path ends in an output register) or flow-through operation (no output register). A burst sequencer walks the low two address bits over four beats in either incrementing or XOR order. While a write in pipelined mode is still waiting for its data, a read of the same word returns the new bytes merged with the stored ones. Every enabled byte of incoming write data has its parity checked against a selectable polarity. An asynchronous output enable can silence the data outputs at any moment.

Top module: `nbt_sram`

## Requirements
- R1: A cycle with adv=0 is a start only when en_a, en_b and en_c are all 1. If any of them is 0, the cycle is a deselect: it writes nothing and dq_drive is 0 in the slot where its read data would appear.
- R2: With flow_mode=0 (pipelined), a read started at clock edge E drives dq_drive=1 and the addressed word on dq_out after edge E+1.
- R3: With flow_mode=1 (flow-through), a read started at edge E drives its word after edge E itself.
- R4: A write started at edge E takes d_in at edge E+2 when flow_mode=0 and at edge E+1 when flow_mode=1.
- R5: Reads and writes may alternate on consecutive cycles with no idle cycle, and each read returns the value left by every earlier write in command order.
- R6: With burst_ilv=0, beat k (k=0..3, where k counts adv=1 cycles after the start, modulo 4) uses the address whose low two bits are (base+k) mod 4, with the upper bits unchanged.
- R7: With burst_ilv=1, beat k uses low two bits base XOR k, with the upper bits unchanged.
- R8: bwe[i]=1 writes d_in[9i+8:9i] into the word. Lanes with bwe[i]=0 keep their stored value. Byte enables are sampled with each command beat.
- R9: par_odd=0 expects the XOR of each 9-bit lane to be 0, and par_odd=1 expects it to be 1. par_err is 1 in the cycle after a write data edge when any enabled lane mismatches, and 0 otherwise. Disabled lanes and non-write slots are not checked.
- R10: oe=0 forces dq_drive=0 and dq_out=0 at once, without waiting for a clock edge.
- R11: In pipelined mode, a read issued the cycle after a write to the same word returns the write data in enabled lanes and the stored data elsewhere.
- R12: While rst_n=0 and right after its release, dq_drive=0 and par_err=0.
- R13: An adv=1 cycle continues the current burst and ignores the enables. If the previous cycle was a deselect, the adv=1 cycle is also a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| flow_mode | input | 1 | 1 = flow-through, 0 = pipelined (static) |
| burst_ilv | input | 1 | 1 = XOR burst order, 0 = incrementing (static) |
| par_odd | input | 1 | Parity polarity for write checking |
| en_a | input | 1 | Chip enable, active high |
| en_b | input | 1 | Chip enable, active high |
| en_c | input | 1 | Chip enable, active high |
| we | input | 1 | 1 = write, 0 = read on a start cycle |
| adv | input | 1 | 1 = advance the current burst |
| addr | input | AW | Word address on a start cycle |
| bwe | input | NL | Per-lane write enables |
| d_in | input | NL*LW | Late write data |
| oe | input | 1 | Asynchronous output enable |
| dq_out | output | NL*LW | Read data, 0 when not driven |
| dq_drive | output | 1 | 1 when the data outputs are driven |
| par_err | output | 1 | Write parity mismatch flag |

## Verification
A wrong burst counter or base register shows up as a wrong word on dq_out in the very next read slot, one cycle after the beat in pipelined mode and in the same cycle in flow-through mode. A write placed in the wrong late slot, or a broken bypass, shows up at the next read of that word. With back-to-back traffic that read comes within one or two cycles. A stuck pipeline valid bit or a parity fault shows up as an unexpected dq_drive or par_err level in the cycle after the edge concerned. The bench therefore compares both flags on every cycle, not only on reads.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
package nbt_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  localparam int BEAT_W = 2;

  // low address bits of burst beat cnt from base, incrementing or XOR order
  function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] base,
                                                 input logic [BEAT_W-1:0] cnt,
                                                 input logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/nbt_seq.sv
`timescale 1ns/1ps
module nbt_seq import nbt_pkg::*; #(
  parameter int AW = 6,
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_all,
  input  logic          we,
  input  logic          adv,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] bwe,
  input  logic          ilv,
  output cmd_e          s1_cmd,
  output logic [AW-1:0] s1_addr,
  output logic [NL-1:0] s1_bwe
);
  localparam int HI_W = AW - BEAT_W;

  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] cnt_q;
  cmd_e              kind_q;

  // named command events
  logic start_c, desel_c;
  assign start_c = !adv && sel_all;
  assign desel_c = !adv && !sel_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      kind_q <= CMD_IDLE;
      s1_bwe <= '0;
    end else begin
      s1_bwe <= bwe;
      if (start_c) begin
        base_q <= addr;
        cnt_q  <= '0;
        kind_q <= we ? CMD_WRITE : CMD_READ;
      end else if (desel_c) begin
        kind_q <= CMD_IDLE;
      end else if (kind_q != CMD_IDLE) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign s1_cmd  = kind_q;
  assign s1_addr = {base_q[AW-1 -: HI_W], beat_low(base_q[BEAT_W-1:0], cnt_q, ilv)};

  // first beat uses the presented address unchanged (R6, R7)
  p_start_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> s1_addr == $past(addr));

  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desel_c |=> s1_cmd == CMD_IDLE);

  p_adv_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_cmd == CMD_IDLE) |=> s1_cmd == CMD_IDLE);

  p_adv_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_cmd != CMD_IDLE) |=>
      (s1_addr[AW-1 -: HI_W] == $past(s1_addr[AW-1 -: HI_W])) && $stable(s1_cmd));

endmodule

// File: rtl/nbt_store.sv
`timescale 1ns/1ps
module nbt_store #(
  parameter int AW = 6,
  parameter int NL = 8,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NL-1:0]    wr_be,
  input  logic [NL*LW-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NL*LW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  // one storage array per byte lane so lanes are written independently
  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) cells[wr_addr] <= wr_data[g*LW +: LW];
    end

    assign rd_data[g*LW +: LW] = cells[rd_addr];
  end

endmodule

// File: rtl/nbt_dout.sv
`timescale 1ns/1ps
module nbt_dout import nbt_pkg::*; #(
  parameter int AW = 6,
  parameter int NL = 8,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow,
  input  logic             par_odd,
  input  logic             oe,
  input  cmd_e             s1_cmd,
  input  logic [AW-1:0]    s1_addr,
  input  logic [NL-1:0]    s1_bwe,
  input  logic [NL*LW-1:0] d_in,
  input  logic [NL*LW-1:0] arr_q,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [NL-1:0]    wr_be,
  output logic [NL*LW-1:0] wr_data,
  output logic [NL*LW-1:0] dq_out,
  output logic             dq_drive,
  output logic             par_err
);
  localparam int DW = NL * LW;

  // take write data lanes where mask is set, stored lanes elsewhere
  function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] stored,
                                                input logic [DW-1:0] fresh,
                                                input logic [NL-1:0] mask);
    logic [DW-1:0] r;
    for (int i = 0; i < NL; i++)
      r[i*LW +: LW] = mask[i] ? fresh[i*LW +: LW] : stored[i*LW +: LW];
    return r;
  endfunction

  // second pipeline stage for the double-late write
  cmd_e          s2_cmd;
  logic [AW-1:0] s2_addr;
  logic [NL-1:0] s2_bwe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_cmd  <= CMD_IDLE;
      s2_addr <= '0;
      s2_bwe  <= '0;
    end else begin
      s2_cmd  <= s1_cmd;
      s2_addr <= s1_addr;
      s2_bwe  <= s1_bwe;
    end
  end

  // write commit slot follows the mode
  assign wr_en   = flow ? (s1_cmd == CMD_WRITE) : (s2_cmd == CMD_WRITE);
  assign wr_addr = flow ? s1_addr : s2_addr;
  assign wr_be   = flow ? s1_bwe  : s2_bwe;
  assign wr_data = d_in;

  // bypass from the write committing at the same edge
  logic          rd_now, byp_hit;
  logic [NL-1:0] fwd_mask;
  logic [DW-1:0] merged;
  assign rd_now   = (s1_cmd == CMD_READ);
  assign byp_hit  = wr_en && (wr_addr == s1_addr);
  assign fwd_mask = byp_hit ? wr_be : '0;
  assign merged   = merge_lanes(arr_q, d_in, fwd_mask);

  logic [DW-1:0] hold_q;
  logic          hold_v;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else begin
      hold_v <= rd_now;
      if (rd_now) hold_q <= merged;
    end
  end

  logic [DW-1:0] data_sel;
  logic          vld_sel;
  assign data_sel = flow ? arr_q  : hold_q;
  assign vld_sel  = flow ? rd_now : hold_v;
  assign dq_drive = oe & vld_sel;
  assign dq_out   = dq_drive ? data_sel : '0;

  // parity of each enabled lane in the data slot
  logic [NL-1:0] lane_bad;
  for (genvar g = 0; g < NL; g++) begin : g_par
    assign lane_bad[g] = wr_be[g] & ((^d_in[g*LW +: LW]) != par_odd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_err <= 1'b0;
    else        par_err <= wr_en & (|lane_bad);
  end

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dq_drive && dq_out == '0));

  p_pipe_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && oe && $past(s1_cmd) == CMD_READ) |-> dq_drive);

  p_flow_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && oe && s1_cmd == CMD_READ) |-> dq_drive);

  p_wr_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && wr_en) |-> $past(s1_cmd) == CMD_WRITE);

  p_par_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(wr_en));

  p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && rd_now && wr_en && wr_addr == s1_addr && wr_be == '1) |=>
      hold_q == $past(d_in));

endmodule

// File: rtl/nbt_sram.sv
`timescale 1ns/1ps
module nbt_sram import nbt_pkg::*; #(
  parameter int AW = 6,
  parameter int NL = 8,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_mode,
  input  logic             burst_ilv,
  input  logic             par_odd,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             en_c,
  input  logic             we,
  input  logic             adv,
  input  logic [AW-1:0]    addr,
  input  logic [NL-1:0]    bwe,
  input  logic [NL*LW-1:0] d_in,
  input  logic             oe,
  output logic [NL*LW-1:0] dq_out,
  output logic             dq_drive,
  output logic             par_err
);
  localparam int DW = NL * LW;

  logic          sel_all;
  cmd_e          s1_cmd;
  logic [AW-1:0] s1_addr;
  logic [NL-1:0] s1_bwe;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [NL-1:0] wr_be;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] arr_q;

  assign sel_all = en_a & en_b & en_c;

  nbt_seq #(.AW(AW), .NL(NL)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_all(sel_all), .we(we), .adv(adv),
    .addr(addr), .bwe(bwe), .ilv(burst_ilv),
    .s1_cmd(s1_cmd), .s1_addr(s1_addr), .s1_bwe(s1_bwe)
  );

  nbt_store #(.AW(AW), .NL(NL), .LW(LW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_addr(s1_addr), .rd_data(arr_q)
  );

  nbt_dout #(.AW(AW), .NL(NL), .LW(LW)) u_dout (
    .clk(clk), .rst_n(rst_n), .flow(flow_mode), .par_odd(par_odd), .oe(oe),
    .s1_cmd(s1_cmd), .s1_addr(s1_addr), .s1_bwe(s1_bwe), .d_in(d_in),
    .arr_q(arr_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .dq_out(dq_out), .dq_drive(dq_drive), .par_err(par_err)
  );

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rst_n |-> (!dq_drive && !par_err));

endmodule

// File: tb/sim_nbt_sram.sv
`timescale 1ns/1ps
module sim_nbt_sram;
  localparam int AW = 6, NL = 8, LW = 9, DW = NL * LW, NOPS = 96;

  logic clk, rst_n, flow_mode, burst_ilv, par_odd, en_a, en_b, en_c, we, adv, oe;
  logic [AW-1:0] addr;
  logic [NL-1:0] bwe;
  logic [DW-1:0] d_in, dq_out;
  logic dq_drive, par_err;

  nbt_sram #(.AW(AW), .NL(NL), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .burst_ilv(burst_ilv),
    .par_odd(par_odd), .en_a(en_a), .en_b(en_b), .en_c(en_c), .we(we), .adv(adv),
    .addr(addr), .bwe(bwe), .d_in(d_in), .oe(oe),
    .dq_out(dq_out), .dq_drive(dq_drive), .par_err(par_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // word whose every lane has XOR equal to odd
  function automatic logic [DW-1:0] mk(input logic [7:0] seed, input logic odd);
    logic [DW-1:0] w;
    for (int i = 0; i < NL; i++) begin
      logic [7:0] d;
      d = 8'(int'(seed) * (i + 3) + i * 29);
      w[i*LW +: LW] = {(^d) ^ odd, d};
    end
    return w;
  endfunction

  // operation list
  logic [2:0]    o_en   [NOPS];
  logic          o_we   [NOPS];
  logic          o_adv  [NOPS];
  logic [AW-1:0] o_addr [NOPS];
  logic [NL-1:0] o_bwe  [NOPS];
  logic [DW-1:0] o_data [NOPS];
  logic [1:0]    e_kind [NOPS];
  logic [DW-1:0] e_rd   [NOPS];
  logic          e_perr [NOPS];
  int n_ops = 0;
  logic [DW-1:0] mdl [1<<AW];

  task automatic add(input logic [2:0] en, input logic w, input logic a,
                     input logic [AW-1:0] ad, input logic [NL-1:0] be,
                     input logic [DW-1:0] dat);
    o_en[n_ops] = en; o_we[n_ops] = w; o_adv[n_ops] = a;
    o_addr[n_ops] = ad; o_bwe[n_ops] = be; o_data[n_ops] = dat;
    n_ops++;
  endtask

  task automatic op_wr(input logic [AW-1:0] ad, input logic [DW-1:0] dat, input logic [NL-1:0] be);
    add(3'b111, 1'b1, 1'b0, ad, be, dat);
  endtask
  task automatic op_rd(input logic [AW-1:0] ad);
    add(3'b111, 1'b0, 1'b0, ad, '0, mk(8'hA5, 1'b1));
  endtask
  task automatic op_adv(input logic [DW-1:0] dat);
    add(3'b111, 1'b0, 1'b1, '0, '1, dat);
  endtask

  // expected results from the requirements, in command order
  task automatic plan();
    logic [1:0] kind = 2'd0;
    logic [AW-1:0] base = '0;
    logic [1:0] cnt = 2'd0;
    for (int i = 0; i < n_ops; i++) begin
      logic [AW-1:0] ea;
      if (!o_adv[i] && o_en[i] == 3'b111) begin
        kind = o_we[i] ? 2'd2 : 2'd1; base = o_addr[i]; cnt = 2'd0;
      end else if (!o_adv[i]) kind = 2'd0;
      else if (kind != 2'd0) cnt = cnt + 2'd1;
      ea = {base[AW-1:2], burst_ilv ? (base[1:0] ^ cnt) : (base[1:0] + cnt)};
      e_kind[i] = kind;
      e_perr[i] = 1'b0;
      e_rd[i]   = '0;
      if (kind == 2'd2) begin
        for (int g = 0; g < NL; g++) if (o_bwe[i][g]) begin
          mdl[ea][g*LW +: LW] = o_data[i][g*LW +: LW];
          if ((^o_data[i][g*LW +: LW]) != par_odd) e_perr[i] = 1'b1;
        end
      end else if (kind == 2'd1) e_rd[i] = mdl[ea];
    end
  endtask

  task automatic step(input logic [2:0] en, input logic w, input logic a,
                      input logic [AW-1:0] ad, input logic [NL-1:0] be,
                      input logic [DW-1:0] din);
    {en_a, en_b, en_c} = en; we = w; adv = a; addr = ad; bwe = be; d_in = din;
    @(negedge clk);
  endtask

  task automatic run(input string tag);
    int rl, wl;
    plan();
    rl = flow_mode ? 0 : 1;
    wl = flow_mode ? 1 : 2;
    for (int c = 0; c < n_ops + 3; c++) begin
      int j, k;
      logic [DW-1:0] din;
      logic exp_drv, exp_err;
      j = c - wl; k = c - rl;
      din = (j >= 0 && j < n_ops) ? o_data[j] : '0;
      if (c < n_ops) step(o_en[c], o_we[c], o_adv[c], o_addr[c], o_bwe[c], din);
      else           step(3'b000, 1'b0, 1'b0, '0, '0, din);
      exp_drv = (k >= 0 && k < n_ops && e_kind[k] == 2'd1);
      chk(dq_drive == exp_drv, tag, "dq_drive", DW'(dq_drive), DW'(exp_drv));
      if (exp_drv) chk(dq_out == e_rd[k], tag, "dq_out", dq_out, e_rd[k]);
      exp_err = (j >= 0 && j < n_ops && e_kind[j] == 2'd2) ? e_perr[j] : 1'b0;
      chk(par_err == exp_err, tag, "par_err", DW'(par_err), DW'(exp_err));
    end
    n_ops = 0;
  endtask

  task automatic do_reset(input logic f, input logic il, input logic od);
    rst_n = 1'b0; flow_mode = f; burst_ilv = il; par_odd = od; oe = 1'b1;
    {en_a, en_b, en_c} = 3'b000; we = 0; adv = 0; addr = '0; bwe = '0; d_in = '0;
    repeat (2) @(negedge clk);
    chk(!dq_drive && !par_err, "R12", "in reset", DW'({dq_drive, par_err}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dq_drive && !par_err, "R12", "after reset", DW'({dq_drive, par_err}), '0);
  endtask

  // table: address, data seed, byte enables -> write then read back
  localparam logic [21:0] TBL [8] = '{
    {6'd3,  8'h11, 8'hFF}, {6'd3,  8'h22, 8'h0F}, {6'd17, 8'h33, 8'hA5},
    {6'd17, 8'h44, 8'h00}, {6'd40, 8'h55, 8'h81}, {6'd63, 8'h66, 8'hFF},
    {6'd0,  8'h77, 8'h3C}, {6'd40, 8'h88, 8'h7E}
  };

  initial begin
    rst_n = 1'b0;
    do_reset(1'b0, 1'b0, 1'b0);

    // R4 pipelined double-late writes, back to back over the array
    for (int a = 0; a < (1 << AW); a++) op_wr(AW'(a), mk(8'(a), 1'b0), '1);
    run("R4 fill");

    // R5 R8 R11 table: alternating write/read on the same word
    for (int t = 0; t < 8; t++) begin
      op_wr(TBL[t][21:16], mk(TBL[t][15:8], 1'b0), TBL[t][7:0]);
      op_rd(TBL[t][21:16]);
    end
    run("R5 R8 R11 R2 table");

    // R6 incrementing burst: write at 6 (6,7,4,5), read at 5 (5,6,7,4)
    op_wr(6'd6, mk(8'h90, 1'b0), '1);
    op_adv(mk(8'h91, 1'b0)); op_adv(mk(8'h92, 1'b0)); op_adv(mk(8'h93, 1'b0));
    op_rd(6'd5); op_adv('0); op_adv('0); op_adv('0); op_adv('0);
    run("R6 R2 burst");

    // R1 R13 deselects: partial enables and advance after deselect
    op_rd(6'd10);
    add(3'b110, 1'b0, 1'b0, 6'd10, '0, '0);
    add(3'b111, 1'b1, 1'b1, 6'd10, '1, mk(8'hEE, 1'b0));
    add(3'b101, 1'b1, 1'b0, 6'd10, '1, mk(8'hDD, 1'b0));
    add(3'b011, 1'b0, 1'b0, 6'd10, '0, '0);
    op_rd(6'd10);
    run("R1 R13 deselect");

    // R9 even polarity: bad lane 3 enabled, then disabled
    begin
      logic [DW-1:0] bad;
      bad = mk(8'h5A, 1'b0);
      bad[3*LW] = ~bad[3*LW];
      op_wr(6'd20, bad, '1);
      op_wr(6'd21, bad, 8'hF7);
      op_rd(6'd21);
      op_rd(6'd20);
      run("R9 parity even");
    end

    // R10 asynchronous output enable
    step(3'b111, 1'b0, 1'b0, 6'd3, '0, '0);
    step(3'b000, 1'b0, 1'b0, '0, '0, '0);
    chk(dq_drive == 1'b1 && dq_out == mdl[3], "R10", "oe high read", dq_out, mdl[3]);
    oe = 1'b0; #0.5;
    chk(!dq_drive && dq_out == '0, "R10", "oe low", dq_out, '0);
    oe = 1'b1; #0.5;
    chk(dq_drive == 1'b1, "R10", "oe restored", DW'(dq_drive), DW'(1));
    step(3'b000, 1'b0, 1'b0, '0, '0, '0);

    // R7 XOR burst order
    do_reset(1'b0, 1'b1, 1'b0);
    op_rd(6'd9); op_adv('0); op_adv('0); op_adv('0);
    op_wr(6'd14, mk(8'hB0, 1'b0), '1);
    op_adv(mk(8'hB1, 1'b0)); op_adv(mk(8'hB2, 1'b0)); op_adv(mk(8'hB3, 1'b0));
    op_rd(6'd13); op_adv('0); op_adv('0); op_adv('0);
    run("R7 xor burst");

    // R3 R4 flow-through, odd polarity, mixed traffic
    do_reset(1'b1, 1'b0, 1'b1);
    op_wr(6'd30, mk(8'hC1, 1'b1), '1); op_rd(6'd30);
    op_wr(6'd30, mk(8'hC2, 1'b1), 8'hF0); op_rd(6'd30);
    op_rd(6'd3); op_wr(6'd31, mk(8'hC3, 1'b1), '1); op_rd(6'd31);
    op_wr(6'd32, mk(8'hC4, 1'b1), '1); op_adv(mk(8'hC5, 1'b1));
    op_rd(6'd34); op_adv('0); op_adv('0); op_adv('0);
    begin
      logic [DW-1:0] bad;
      bad = mk(8'hC6, 1'b1);
      bad[0] = ~bad[0];
      op_wr(6'd50, bad, 8'h01);
      op_rd(6'd50);
    end
    run("R3 R4 R9 flow");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule